// File: doc/BRIEF.md
# TLB Replacement Pointer Counter

This block keeps the index of the unified TLB entry that the next software TLB-load instruction will overwrite. The index steps forward on every access to the unified TLB. It wraps to zero at a boundary that software programs. When the boundary is zero, it wraps only after the all-ones value. Software can read the pointer and write it directly. TLB-load operations leave the pointer where it is.

A small MMU control register sits beside the counter and holds three settings:
- a translation enable bit, which also gates MMU fault reporting;
- a bit that selects single or multiple virtual-space mode;
- a bit that limits store-queue access to privileged mode.

A write-one bit in the same register sends a one-cycle pulse that clears all unified and instruction TLB valid bits. That bit always reads as zero.

Top module: `tlb_repl_ptr`

## Requirements
- R1: Each cycle with `acc_i`=1, `load_i`=0 and `ptr_wr_i`=0 advances `ptr_o` by one modulo 64 in the following cycle, unless R2 applies.
- R2: When `bound_i` is nonzero and `ptr_o` equals `bound_i` at such an access, `ptr_o` becomes 0.
- R3: A pointer above `bound_i` keeps advancing through the values above the boundary up to 0x3F, then wraps to 0.
- R4: With `bound_i`=0 the pointer free-runs 0, 1, …, 0x3F, 0.
- R5: A cycle with `load_i`=1 does not change `ptr_o`, even if `acc_i`=1 in the same cycle.
- R6: `ptr_wr_i`=1 loads `ptr_wdata_i` into the pointer in the next cycle and takes priority over an access in the same cycle.
- R7: `ctl_wr_i` stores `ctl_wdata_i` bit 0 (translation enable), bit 1 (single virtual space) and bit 3 (store queue privileged-only). These bits read back at the same positions on `ctl_rd_o` and drive `xlat_en_o`, `single_space_o` and `sq_priv_only_o`.
- R8: A control write with bit 2 set raises `inval_pulse_o` for exactly one cycle, in the cycle after the write. Bit 2 of `ctl_rd_o` always reads 0.
- R9: `mmu_fault_o` follows `mmu_fault_i` only while translation is enabled. Otherwise it is 0.
- R10: After reset the pointer, all control bits and `inval_pulse_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_i | input | 1 | Unified TLB access strobe |
| load_i | input | 1 | TLB-load instruction strobe |
| bound_i | input | 6 | Wrap boundary (0 = full range) |
| ptr_wr_i | input | 1 | Software write of the pointer |
| ptr_wdata_i | input | 6 | Pointer write data |
| ctl_wr_i | input | 1 | Control register write |
| ctl_wdata_i | input | 4 | Control write data |
| mmu_fault_i | input | 1 | Raw MMU fault request |
| ptr_o | output | 6 | Current replacement pointer |
| ctl_rd_o | output | 4 | Control register readback |
| xlat_en_o | output | 1 | Address translation enabled |
| single_space_o | output | 1 | Single virtual-space mode |
| sq_priv_only_o | output | 1 | Store queues privileged-only |
| inval_pulse_o | output | 1 | Clear all TLB valid bits |
| mmu_fault_o | output | 1 | Gated MMU fault |

## Verification
The bench builds the block with its default 6-bit pointer, so all 64 entries can be reached. One free-running pass covers every value and the natural wrap from 0x3F to 0. A small boundary of 10 makes the early wrap fast to reach. Writing 0x3D above that boundary puts the over-boundary climb to 0x3F and its wrap within a few accesses.

// File: rtl/tlb_repl_pkg.sv
package tlb_repl_pkg;
  // Control register layout, MSB first
  typedef struct packed {
    logic sq_priv;       // bit 3
    logic inval;         // bit 2, write-one, reads zero
    logic single_space;  // bit 1
    logic xlat_en;       // bit 0
  } mmu_ctl_t;
  localparam int CTL_W = $bits(mmu_ctl_t);
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/repl_ptr_ctr.sv
module repl_ptr_ctr #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] bound_i,
  input  logic             wr_i,
  input  logic [PTR_W-1:0] wdata_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;
  logic             step;
  logic             hit_bound;

  assign step      = acc_i & ~load_i;
  assign hit_bound = (bound_i != '0) && (ptr_q == bound_i);
  assign ptr_en    = wr_i | step;

  always_comb begin
    ptr_d = ptr_q;
    if (wr_i)           ptr_d = wdata_i;
    else if (hit_bound) ptr_d = '0;
    else                ptr_d = ptr_q + PTR_W'(1);  // natural wrap past all-ones
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/mmu_ctl_reg.sv
module mmu_ctl_reg
  import tlb_repl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_i,
  input  mmu_ctl_t wdata_i,
  output mmu_ctl_t ctl_o,
  output logic     inval_pulse_o
);
  logic xlat_q, single_q, sq_q, pulse_q;
  logic xlat_d, single_d, sq_d, pulse_d;

  always_comb begin
    xlat_d   = xlat_q;
    single_d = single_q;
    sq_d     = sq_q;
    if (wr_i) begin
      xlat_d   = wdata_i.xlat_en;
      single_d = wdata_i.single_space;
      sq_d     = wdata_i.sq_priv;
    end
    pulse_d = wr_i & wdata_i.inval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlat_q   <= 1'b0;
      single_q <= 1'b0;
      sq_q     <= 1'b0;
    end else if (wr_i) begin
      xlat_q   <= xlat_d;
      single_q <= single_d;
      sq_q     <= sq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  always_comb begin
    ctl_o              = '0;
    ctl_o.xlat_en      = xlat_q;
    ctl_o.single_space = single_q;
    ctl_o.sq_priv      = sq_q;
  end

  assign inval_pulse_o = pulse_q;
endmodule

// File: rtl/tlb_repl_ptr.sv
module tlb_repl_ptr
  import tlb_repl_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] bound_i,
  input  logic             ptr_wr_i,
  input  logic [PTR_W-1:0] ptr_wdata_i,
  input  logic             ctl_wr_i,
  input  logic [3:0]       ctl_wdata_i,
  input  logic             mmu_fault_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [3:0]       ctl_rd_o,
  output logic             xlat_en_o,
  output logic             single_space_o,
  output logic             sq_priv_only_o,
  output logic             inval_pulse_o,
  output logic             mmu_fault_o
);
  logic     rst_n_s;
  mmu_ctl_t ctl;

  rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  repl_ptr_ctr #(.PTR_W(PTR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n_s), .acc_i(acc_i), .load_i(load_i),
    .bound_i(bound_i), .wr_i(ptr_wr_i), .wdata_i(ptr_wdata_i), .ptr_o(ptr_o)
  );

  mmu_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n_s), .wr_i(ctl_wr_i),
    .wdata_i(mmu_ctl_t'(ctl_wdata_i)), .ctl_o(ctl), .inval_pulse_o(inval_pulse_o)
  );

  assign ctl_rd_o       = ctl;
  assign xlat_en_o      = ctl.xlat_en;
  assign single_space_o = ctl.single_space;
  assign sq_priv_only_o = ctl.sq_priv;
  assign mmu_fault_o    = mmu_fault_i & ctl.xlat_en;
endmodule

// File: rtl/tlb_repl_ptr_chk.sv
module tlb_repl_ptr_chk #(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_i,
  input logic             load_i,
  input logic [PTR_W-1:0] bound_i,
  input logic             ptr_wr_i,
  input logic [PTR_W-1:0] ptr_wdata_i,
  input logic             ctl_wr_i,
  input logic [3:0]       ctl_wdata_i,
  input logic             mmu_fault_i,
  input logic [PTR_W-1:0] ptr_o,
  input logic [3:0]       ctl_rd_o,
  input logic             xlat_en_o,
  input logic             inval_pulse_o,
  input logic             mmu_fault_o
);
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !load_i && !ptr_wr_i && !(bound_i != '0 && ptr_o == bound_i))
    |=> ptr_o == ($past(ptr_o) + PTR_W'(1)));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !load_i && !ptr_wr_i && bound_i != '0 && ptr_o == bound_i)
    |=> ptr_o == '0);

  p_load_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !ptr_wr_i) |=> $stable(ptr_o));

  p_wr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_i |=> ptr_o == $past(ptr_wdata_i));

  p_ctl_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_i |=> xlat_en_o == $past(ctl_wdata_i[0]));

  p_inval_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && ctl_wdata_i[2]) |=> inval_pulse_o);

  p_inval_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr_i && ctl_wdata_i[2]) |=> !inval_pulse_o);

  p_inval_reads0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd_o[2] == 1'b0);

  p_fault_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !xlat_en_o |-> !mmu_fault_o);
endmodule

bind tlb_repl_ptr tlb_repl_ptr_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .acc_i(acc_i), .load_i(load_i),
  .bound_i(bound_i), .ptr_wr_i(ptr_wr_i), .ptr_wdata_i(ptr_wdata_i),
  .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .mmu_fault_i(mmu_fault_i),
  .ptr_o(ptr_o), .ctl_rd_o(ctl_rd_o), .xlat_en_o(xlat_en_o),
  .inval_pulse_o(inval_pulse_o), .mmu_fault_o(mmu_fault_o)
);

// File: tb/sim_tlb_repl_ptr.sv
`timescale 1ns/1ps
module sim_tlb_repl_ptr;
  localparam int PTR_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_i = 1'b0, load_i = 1'b0, ptr_wr_i = 1'b0, ctl_wr_i = 1'b0;
  logic             mmu_fault_i = 1'b0;
  logic [PTR_W-1:0] bound_i = '0, ptr_wdata_i = '0;
  logic [3:0]       ctl_wdata_i = '0;
  logic [PTR_W-1:0] ptr_o;
  logic [3:0]       ctl_rd_o;
  logic             xlat_en_o, single_space_o, sq_priv_only_o, inval_pulse_o, mmu_fault_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tlb_repl_ptr #(.PTR_W(PTR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .load_i(load_i), .bound_i(bound_i),
    .ptr_wr_i(ptr_wr_i), .ptr_wdata_i(ptr_wdata_i), .ctl_wr_i(ctl_wr_i),
    .ctl_wdata_i(ctl_wdata_i), .mmu_fault_i(mmu_fault_i), .ptr_o(ptr_o),
    .ctl_rd_o(ctl_rd_o), .xlat_en_o(xlat_en_o), .single_space_o(single_space_o),
    .sq_priv_only_o(sq_priv_only_o), .inval_pulse_o(inval_pulse_o),
    .mmu_fault_o(mmu_fault_o)
  );

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one clock: inputs already set after the previous edge; sample 1 ns past the edge
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    acc_i = 0; load_i = 0; ptr_wr_i = 0; ctl_wr_i = 0;
  endtask

  task automatic access_n(int n);
    acc_i = 1;
    for (int i = 0; i < n; i++) tick();
    acc_i = 0;
  endtask

  task automatic set_ptr(logic [PTR_W-1:0] v);
    ptr_wr_i = 1; ptr_wdata_i = v; tick(); ptr_wr_i = 0;
  endtask

  task automatic t_reset();
    chk("R10 ptr", ptr_o, 0);
    chk("R10 ctl", ctl_rd_o, 0);
    chk("R10 pulse", inval_pulse_o, 0);
  endtask

  task automatic t_step_and_bound();
    bound_i = 6'd10;
    access_n(5);
    chk("R1 step", ptr_o, 5);
    access_n(5);
    chk("R1 reach bound", ptr_o, 10);
    access_n(1);
    chk("R2 wrap at bound", ptr_o, 0);
  endtask

  task automatic t_above_bound();
    bound_i = 6'd10;
    set_ptr(6'h3D);
    chk("R6 write", ptr_o, 'h3D);
    access_n(1); chk("R3 3E", ptr_o, 'h3E);
    access_n(1); chk("R3 3F", ptr_o, 'h3F);
    access_n(1); chk("R3 wrap 0", ptr_o, 0);
    access_n(1); chk("R3 resume", ptr_o, 1);
  endtask

  task automatic t_free_run();
    bound_i = '0;
    set_ptr('0);
    acc_i = 1;
    for (int i = 1; i <= 64; i++) begin
      tick();
      chk("R4 free run", ptr_o, i % 64);
    end
    acc_i = 0;
  endtask

  task automatic t_load();
    bound_i = '0;
    set_ptr(6'd7);
    load_i = 1; tick(); load_i = 0;
    chk("R5 load alone", ptr_o, 7);
    load_i = 1; acc_i = 1; tick(); idle();
    chk("R5 load with access", ptr_o, 7);
  endtask

  task automatic t_write_wins();
    bound_i = '0;
    acc_i = 1; ptr_wr_i = 1; ptr_wdata_i = 6'h20; tick(); idle();
    chk("R6 write beats access", ptr_o, 'h20);
  endtask

  task automatic t_ctl();
    ctl_wr_i = 1; ctl_wdata_i = 4'b1011; tick(); idle();
    chk("R7 readback", ctl_rd_o, 'hB);
    chk("R7 xlat", xlat_en_o, 1);
    chk("R7 single", single_space_o, 1);
    chk("R7 sq", sq_priv_only_o, 1);
    chk("R8 no pulse", inval_pulse_o, 0);
    ctl_wr_i = 1; ctl_wdata_i = 4'b0010; tick(); idle();
    chk("R7 readback 2", ctl_rd_o, 'h2);
  endtask

  task automatic t_inval();
    ctl_wr_i = 1; ctl_wdata_i = 4'b0101; tick(); idle();
    chk("R8 pulse", inval_pulse_o, 1);
    chk("R8 reads zero", ctl_rd_o, 'h1);
    tick();
    chk("R8 pulse ends", inval_pulse_o, 0);
  endtask

  task automatic t_fault();
    ctl_wr_i = 1; ctl_wdata_i = 4'b0000; tick(); idle();
    mmu_fault_i = 1; #1;
    chk("R9 gated off", mmu_fault_o, 0);
    ctl_wr_i = 1; ctl_wdata_i = 4'b0001; tick(); idle();
    chk("R9 passes", mmu_fault_o, 1);
    mmu_fault_i = 0; #1;
    chk("R9 follows", mmu_fault_o, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_step_and_bound();
    t_above_bound();
    t_free_run();
    t_load();
    t_write_wins();
    t_ctl();
    t_inval();
    t_fault();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule